// File: doc/BRIEF.md
# Receive Error Priority Reporter

This block sits behind the bit slicer and subframe decoder of a digital audio receiver. It gathers the error events raised while subframes arrive and holds the most severe one in a 3-bit code. A lower-ranked event never replaces a higher code that is already held. Software or board logic clears the held code by keeping a select input high for long enough. A short glitch on that input does not count as a clear.

The block also tracks lock from preamble arrivals. Lock is gained after a run of frame preambles followed by a block preamble. Lock is dropped after a run of missed preambles in a row. At every sample boundary the block updates two flags: a per-sample error flag and a combined flag that also includes the received validity bit. Downstream filters use these flags to conceal bad samples.

Top module: `rx_error_reporter`

## Requirements
- R1: `err_code_o` encodes the held event as follows: 0 none, 1 validity set, 2 low confidence, 3 slipped sample, 4 channel status CRC mismatch, 5 parity error, 6 biphase violation, 7 not locked. The cycle after events arrive, the code becomes the larger of the held code and the highest code present. Without a clear, the code never decreases.
- R2: A clear happens only on the 9th consecutive cycle in which `sel_i` is sampled high. A high run of 8 cycles or fewer leaves the code unchanged. A run of any length clears once.
- R3: In the clear cycle, the held code is replaced by the highest code present in that same cycle, so an event arriving with the clear is kept.
- R4: At a `sample_end_i` strobe, a parity error is raised when the XOR of all bits of `sub_data_i` is 1. The validity bit is `sub_data_i[24]`.
- R5: While unlocked, frame preambles are counted up to 3. A block preamble declares lock when the count has reached 3; otherwise the count restarts. A preamble timeout while unlocked also restarts the count.
- R6: While locked, 4 consecutive `pre_timeout_i` strobes with no frame or block preamble between them drop lock. Any preamble restarts the miss count.
- R7: The cycle after `sample_end_i`, `erf_o` equals the OR of three terms: that sample's parity error, any `bip_err_i` seen since the previous strobe (including the strobe cycle), and not-locked.
- R8: `verf_o` is updated at the same time as `erf_o` and equals `erf_o` ORed with the sample's validity bit.
- R9: A CRC event (code 4) is taken only when `crc_err_i`, `blk_start_i` and `pro_fmt_i` are all high in the same cycle.
- R10: During reset, `err_code_o`=0, `locked_o`=0, `erf_o`=1 and `verf_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_pre_i | input | 1 | Frame preamble seen (pulse) |
| block_pre_i | input | 1 | Block preamble seen (pulse) |
| pre_timeout_i | input | 1 | Expected preamble missed (pulse) |
| sample_end_i | input | 1 | Subframe complete, `sub_data_i` valid (pulse) |
| sub_data_i | input | 28 | Received subframe bits after the preamble |
| bip_err_i | input | 1 | Biphase coding violation (pulse) |
| low_conf_i | input | 1 | Low slicer confidence (pulse) |
| slip_i | input | 1 | Stereo sample dropped or repeated (pulse) |
| crc_err_i | input | 1 | Channel status CRC mismatch |
| blk_start_i | input | 1 | Channel status block start (pulse) |
| pro_fmt_i | input | 1 | Professional channel status format |
| sel_i | input | 1 | Clear request, qualified by its width |
| err_code_o | output | 3 | Held highest error code |
| locked_o | output | 1 | Preamble lock state |
| erf_o | output | 1 | Per-sample error flag |
| verf_o | output | 1 | Validity-or-error flag |

## Verification
The bench drives select runs of exactly 8 and 9 cycles. A design that clears one cycle early, or on every cycle of a long run, gives the wrong code after the run. It places an event in the clear cycle itself, which a design that zeroes the code on clear would lose. It sends a block preamble after only two frame preambles, and it breaks a run of timeouts with a single preamble, to catch counters that do not restart. It also raises the CRC input with the qualifiers missing, and sends odd and even parity with the validity bit set, to check the gating of each event.

// File: rtl/rx_err_pkg.sv
package rx_err_pkg;
  localparam int CODE_W = 3;
  localparam int NCODE  = 1 << CODE_W;
  typedef enum logic [CODE_W-1:0] {
    E_NONE  = 3'd0,
    E_VALID = 3'd1,
    E_CONF  = 3'd2,
    E_SLIP  = 3'd3,
    E_CRC   = 3'd4,
    E_PAR   = 3'd5,
    E_BIP   = 3'd6,
    E_NLOCK = 3'd7
  } err_code_e;
endpackage

// File: rtl/rx_lock_tracker.sv
module rx_lock_tracker #(
  parameter int ACQ_FRAMES  = 3,
  parameter int LOSS_MISSES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_pre_i,
  input  logic block_pre_i,
  input  logic pre_timeout_i,
  output logic locked_o
);
  localparam int AW = $clog2(ACQ_FRAMES + 1);
  localparam int MW = $clog2(LOSS_MISSES);
  localparam logic [AW-1:0] ACQ_TOP  = AW'(ACQ_FRAMES);
  localparam logic [MW-1:0] MISS_TOP = MW'(LOSS_MISSES - 1);

  logic [AW-1:0] acq_q;
  logic [MW-1:0] miss_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_o <= 1'b0;
      acq_q    <= '0;
      miss_q   <= '0;
    end else if (!locked_o) begin
      if (block_pre_i) begin
        if (acq_q == ACQ_TOP) locked_o <= 1'b1;
        acq_q  <= '0;
        miss_q <= '0;
      end else if (frame_pre_i) begin
        if (acq_q != ACQ_TOP) acq_q <= acq_q + 1'b1;
      end else if (pre_timeout_i) begin
        acq_q <= '0;
      end
    end else begin
      if (frame_pre_i || block_pre_i) begin
        miss_q <= '0;
      end else if (pre_timeout_i) begin
        if (miss_q == MISS_TOP) begin
          locked_o <= 1'b0;
          miss_q   <= '0;
        end else begin
          miss_q <= miss_q + 1'b1;
        end
      end
    end
  end

  AST_LOCK_NEEDS_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(block_pre_i)); // R5
  AST_UNLOCK_NEEDS_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_o) |-> $past(pre_timeout_i) && !$past(frame_pre_i) && !$past(block_pre_i)); // R6
endmodule

// File: rtl/sel_clear_qual.sv
module sel_clear_qual #(
  parameter int CLR_MIN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  output logic clr_o
);
  localparam int CW = $clog2(CLR_MIN + 2);
  localparam logic [CW-1:0] HI_ARM = CW'(CLR_MIN);
  localparam logic [CW-1:0] HI_SAT = CW'(CLR_MIN + 1);

  logic [CW-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             hi_q <= '0;
    else if (!sel_i)         hi_q <= '0;
    else if (hi_q != HI_SAT) hi_q <= hi_q + 1'b1;
  end

  // fires once, on the first cycle the run exceeds CLR_MIN
  assign clr_o = sel_i && (hi_q == HI_ARM);

  AST_CLR_NEEDS_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |-> $past(sel_i)); // R2
  AST_CLR_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |=> !clr_o); // R2
endmodule

// File: rtl/err_code_latch.sv
module err_code_latch
  import rx_err_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCODE-1:0]  ev_i,
  input  logic              clr_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] cand;

  always_comb begin
    cand = '0;
    for (int k = 0; k < NCODE; k++)
      if (ev_i[k]) cand = CODE_W'(k);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            code_o <= E_NONE;
    else if (clr_i)         code_o <= cand;
    else if (cand > code_o) code_o <= cand;
  end

  AST_NO_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> code_o >= $past(code_o)); // R1
  AST_TOP_EVENT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i[NCODE-1] |=> code_o == E_NLOCK); // R1
endmodule

// File: rtl/rx_error_reporter.sv
module rx_error_reporter
  import rx_err_pkg::*;
#(
  parameter int SUB_W       = 28,
  parameter int V_POS       = 24,
  parameter int ACQ_FRAMES  = 3,
  parameter int LOSS_MISSES = 4,
  parameter int CLR_MIN     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_pre_i,
  input  logic              block_pre_i,
  input  logic              pre_timeout_i,
  input  logic              sample_end_i,
  input  logic [SUB_W-1:0]  sub_data_i,
  input  logic              bip_err_i,
  input  logic              low_conf_i,
  input  logic              slip_i,
  input  logic              crc_err_i,
  input  logic              blk_start_i,
  input  logic              pro_fmt_i,
  input  logic              sel_i,
  output logic [CODE_W-1:0] err_code_o,
  output logic              locked_o,
  output logic              erf_o,
  output logic              verf_o
);
  logic             clr;
  logic             bip_acc_q;
  logic             par_bad, v_bit, bip_any, samp_err;
  logic [NCODE-1:0] ev;

  rx_lock_tracker #(.ACQ_FRAMES(ACQ_FRAMES), .LOSS_MISSES(LOSS_MISSES)) u_lock (
    .clk_i, .rst_ni, .frame_pre_i, .block_pre_i, .pre_timeout_i, .locked_o
  );

  sel_clear_qual #(.CLR_MIN(CLR_MIN)) u_clr (
    .clk_i, .rst_ni, .sel_i, .clr_o(clr)
  );

  assign par_bad  = ^sub_data_i;
  assign v_bit    = sub_data_i[V_POS];
  assign bip_any  = bip_acc_q | bip_err_i;
  assign samp_err = par_bad | bip_any | ~locked_o;

  always_comb begin
    ev          = '0;
    ev[E_VALID] = sample_end_i & v_bit;
    ev[E_CONF]  = low_conf_i;
    ev[E_SLIP]  = slip_i;
    ev[E_CRC]   = crc_err_i & blk_start_i & pro_fmt_i;
    ev[E_PAR]   = sample_end_i & par_bad;
    ev[E_BIP]   = bip_err_i;
    ev[E_NLOCK] = ~locked_o;
  end

  err_code_latch u_latch (
    .clk_i, .rst_ni, .ev_i(ev), .clr_i(clr), .code_o(err_code_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bip_acc_q <= 1'b0;
      erf_o     <= 1'b1;
      verf_o    <= 1'b1;
    end else if (sample_end_i) begin
      bip_acc_q <= 1'b0;
      erf_o     <= samp_err;
      verf_o    <= samp_err | v_bit;
    end else if (bip_err_i) begin
      bip_acc_q <= 1'b1;
    end
  end

  AST_UNLOCKED_ERF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_end_i && !locked_o |=> erf_o); // R7
  AST_VERF_COVERS_ERF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erf_o |-> verf_o); // R8
  AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_end_i |=> $stable(erf_o) && $stable(verf_o)); // R7
endmodule

// File: tb/tb_rx_error_reporter.sv
module tb_rx_error_reporter;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic frame_pre, block_pre, pre_to, samp_end, bip, lowc, slip, crc, blk, pro, sel;
  logic [27:0] sub;
  logic [2:0] code;
  logic locked, erf, verf;

  int checks = 0, errors = 0;
  bit done = 0;

  // model state
  int m_code = 0, m_acq = 0, m_miss = 0, m_hi = 0;
  bit m_lock = 0, m_bip = 0, m_erf = 1, m_verf = 1;

  always #10 clk = ~clk;

  rx_error_reporter dut (
    .clk_i(clk), .rst_ni, .frame_pre_i(frame_pre), .block_pre_i(block_pre),
    .pre_timeout_i(pre_to), .sample_end_i(samp_end), .sub_data_i(sub),
    .bip_err_i(bip), .low_conf_i(lowc), .slip_i(slip), .crc_err_i(crc),
    .blk_start_i(blk), .pro_fmt_i(pro), .sel_i(sel),
    .err_code_o(code), .locked_o(locked), .erf_o(erf), .verf_o(verf)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    {frame_pre, block_pre, pre_to, samp_end, bip, lowc, slip, crc, blk, pro, sel} = '0;
    sub = '0;
  endtask

  function automatic int cand_of();
    int c = 0;
    if (samp_end && sub[24]) c = 1;
    if (lowc) c = 2;
    if (slip) c = 3;
    if (crc && blk && pro) c = 4;
    if (samp_end && (^sub)) c = 5;
    if (bip) c = 6;
    if (!m_lock) c = 7;
    return c;
  endfunction

  // advance one clock, update model, compare at falling edge
  task automatic tick();
    int c; bit clr, se, nl; int na, nm;
    c   = cand_of();
    clr = sel && (m_hi == 8);
    nl = m_lock; na = m_acq; nm = m_miss;
    if (!m_lock) begin
      if (block_pre) begin nl = (m_acq == 3); na = 0; nm = 0; end
      else if (frame_pre) begin if (m_acq < 3) na = m_acq + 1; end
      else if (pre_to) na = 0;
    end else begin
      if (frame_pre || block_pre) nm = 0;
      else if (pre_to) begin
        if (m_miss == 3) begin nl = 0; nm = 0; end else nm = m_miss + 1;
      end
    end
    if (samp_end) begin
      se = (^sub) | m_bip | bip | !m_lock;
      m_erf = se; m_verf = se | sub[24]; m_bip = 0;
    end else if (bip) m_bip = 1;
    if (clr) m_code = c; else if (c > m_code) m_code = c;
    if (!sel) m_hi = 0; else if (m_hi < 9) m_hi++;
    m_lock = nl; m_acq = na; m_miss = nm;
    @(posedge clk);
    @(negedge clk);
    chk("R1 code", code, m_code);
    chk("R5 locked", locked, m_lock);
    chk("R7 erf", erf, m_erf);
    chk("R8 verf", verf, m_verf);
  endtask

  task automatic acquire();
    for (int i = 0; i < 3; i++) begin idle(); frame_pre = 1; tick(); end
    idle(); block_pre = 1; tick();
    idle();
  endtask

  task automatic sel_run(int n);
    for (int i = 0; i < n; i++) begin idle(); sel = 1; tick(); end
    idle(); tick();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    idle();
    @(negedge clk);
    chk("R10 code", code, 0);
    chk("R10 locked", locked, 0);
    chk("R10 erf", erf, 1);
    chk("R10 verf", verf, 1);
    rst_ni = 1'b1;
    tick();
    chk("R1 unlocked code", code, 7);

    // R5: block preamble too early restarts the count
    idle(); frame_pre = 1; tick(); tick();
    idle(); block_pre = 1; tick();
    chk("R5 early block", locked, 0);
    acquire();
    chk("R5 acquired", locked, 1);

    // R2: 8 highs keep the code, 9 clear it
    sel_run(8);
    chk("R2 short run", code, 7);
    sel_run(9);
    chk("R2 cleared", code, 0);
    sel_run(20);
    chk("R2 long run", code, 0);

    // R4/R7/R8: odd parity
    idle(); samp_end = 1; sub = 28'h0000001; tick();
    chk("R4 parity code", code, 5);
    chk("R7 parity erf", erf, 1);
    sel_run(9);
    // even parity with validity
    idle(); samp_end = 1; sub = 28'h1000001; tick();
    chk("R4 validity code", code, 1);
    chk("R7 clean erf", erf, 0);
    chk("R8 verf from v", verf, 1);
    // R7: biphase seen mid-sample
    idle(); bip = 1; tick(); idle(); tick();
    samp_end = 1; tick(); idle();
    chk("R7 bip erf", erf, 1);
    chk("R1 bip code", code, 6);
    idle(); lowc = 1; tick();
    chk("R1 lower kept out", code, 6);
    sel_run(9);

    // R9: CRC gating
    idle(); crc = 1; blk = 1; tick();
    idle(); crc = 1; pro = 1; tick();
    chk("R9 gated crc", code, 0);
    idle(); crc = 1; blk = 1; pro = 1; tick();
    chk("R9 crc taken", code, 4);

    // R3: event in the clear cycle
    for (int i = 0; i < 8; i++) begin idle(); sel = 1; tick(); end
    idle(); sel = 1; slip = 1; tick();
    chk("R3 event kept", code, 3);
    idle(); tick();

    // R6: miss run broken by a preamble, then full run
    for (int i = 0; i < 3; i++) begin idle(); pre_to = 1; tick(); end
    idle(); frame_pre = 1; tick();
    for (int i = 0; i < 3; i++) begin idle(); pre_to = 1; tick(); end
    chk("R6 still locked", locked, 1);
    idle(); pre_to = 1; tick();
    chk("R6 lost", locked, 0);
    idle(); tick();
    chk("R6 code", code, 7);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int r;
      idle();
      r = $urandom_range(0, 99);
      if (r < 25) frame_pre = 1;
      else if (r < 29) block_pre = 1;
      else if (r < 35) pre_to = 1;
      samp_end = ($urandom_range(0, 99) < 20);
      sub  = 28'($urandom);
      bip  = ($urandom_range(0, 99) < 3);
      lowc = ($urandom_range(0, 99) < 3);
      slip = ($urandom_range(0, 99) < 2);
      crc  = ($urandom_range(0, 99) < 10);
      blk  = ($urandom_range(0, 99) < 20);
      pro  = ($urandom_range(0, 99) < 50);
      sel  = ((n / 12) % 3 == 0) && ($urandom_range(0, 99) < 97);
      tick();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule